// File: doc/BRIEF.md
# Delegated Interrupt Pending Selector

This block decides which local interrupt a hart should take in the current cycle. It takes the raw pending and enable vectors, two delegation masks (machine-to-supervisor and hypervisor-to-guest), the current privilege level, the virtualization flag and the two global interrupt-enable bits. It reports whether any interrupt may be taken now and, if so, the index of the winner.

Each interrupt line belongs to one of three delegation groups, chosen by its bits in the two masks. Each group is gated by its own global enable, and that enable depends on privilege. The supervisor-side enable splits into a host enable and a guest enable, both derived from the virtualization flag. Among the lines that pass their gates, the lowest index wins. The result can be taken straight from the logic or through one register stage, chosen by a parameter.

Top module: `irq_delegated_select`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `irq_valid_o` is 0 and `irq_idx_o` is 0.
- R2: Only lines that are both pending and enabled (`pend_i & en_i`) can be selected. A pending line whose enable bit is 0 is never reported.
- R3: Privilege is encoded as U=0, S=1, M=3 (2 is unused and treated numerically). The machine-level global enable is true when the privilege is below 3, or when it equals 3 and `mie_i` is 1.
- R4: The supervisor-level global enable is true when the privilege is 0, or when it equals 1 and `sie_i` is 1.
- R5: A line whose `mdeleg_i` bit is 0 is allowed through only when the machine-level enable is true.
- R6: A line whose `mdeleg_i` bit is 1 and whose `hdeleg_i` bit is 0 is allowed through only when `virt_i` is 1 or the supervisor-level enable is true.
- R7: A line whose `mdeleg_i` and `hdeleg_i` bits are both 1 is allowed through only when `virt_i` is 1 and the supervisor-level enable is true.
- R8: When several lines pass their gates, `irq_idx_o` is the lowest bit index among them and `irq_valid_o` is 1.
- R9: When no line passes, `irq_valid_o` is 0 and `irq_idx_o` is 0.
- R10: With `REG_OUT`=1 (the default), both outputs reflect the inputs sampled at the previous rising clock edge. With `REG_OUT`=0 they follow the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | N | Pending interrupt lines |
| en_i | input | N | Per-line enable bits |
| mdeleg_i | input | N | Machine-to-supervisor delegation mask |
| hdeleg_i | input | N | Hypervisor-to-guest delegation mask |
| priv_i | input | 2 | Current privilege (U=0, S=1, M=3) |
| virt_i | input | 1 | Hart is running a virtualized guest |
| mie_i | input | 1 | Machine global interrupt enable |
| sie_i | input | 1 | Supervisor global interrupt enable |
| irq_valid_o | output | 1 | An interrupt is to be taken |
| irq_idx_o | output | $clog2(N) | Index of the chosen interrupt |

## Verification
The bench targets the privilege boundaries, where an off-by-one compare would either let a machine-level line through in machine mode with `mie_i` clear, or block a supervisor line in user mode. It drives the reserved privilege value and both settings of `virt_i`. A design that swaps the host and guest enables would take a guest line outside virtualization, or drop a host line inside it. It also places winners at bits 0 and N-1 and in dense vectors, to catch a picker that favours the highest index or loses the top bit. It checks that an enabled-but-not-pending line and a pending-but-disabled line are both ignored.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  // A level's interrupts are globally on when running below it, or at it with its IE bit set.
  function automatic logic level_open(input logic [1:0] cur, input priv_e lvl, input logic ie);
    return (cur < lvl) || ((cur == lvl) && ie);
  endfunction

  // Host-side supervisor enable: a guest running always lets host-owned lines in.
  function automatic logic host_open(input logic virt, input logic s_open);
    return virt | s_open;
  endfunction

  // Guest-side enable: only while virtualized and supervisor gate is open.
  function automatic logic guest_open(input logic virt, input logic s_open);
    return virt & s_open;
  endfunction

endpackage

// File: rtl/irq_gate_en.sv
module irq_gate_en
  import irq_sel_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  input  logic       mie_i,
  input  logic       sie_i,
  output logic       m_en_o,
  output logic       s_en_o,
  output logic       hs_en_o,
  output logic       vs_en_o
);

  always_comb begin
    m_en_o  = level_open(priv_i, PRIV_MACH, mie_i);
    s_en_o  = level_open(priv_i, PRIV_SUPER, sie_i);
    hs_en_o = host_open(virt_i, s_en_o);
    vs_en_o = guest_open(virt_i, s_en_o);
  end

endmodule

// File: rtl/irq_group_mask.sv
module irq_group_mask #(
  parameter int N = 64
) (
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] mdeleg_i,
  input  logic [N-1:0] hdeleg_i,
  input  logic         m_en_i,
  input  logic         hs_en_i,
  input  logic         vs_en_i,
  output logic [N-1:0] surv_o
);

  logic [N-1:0] act_w;
  assign act_w = pend_i & en_i;

  for (genvar b = 0; b < N; b++) begin : g_bit
    logic gate_w;
    always_comb begin
      unique case ({mdeleg_i[b], hdeleg_i[b]})
        2'b10:   gate_w = hs_en_i;
        2'b11:   gate_w = vs_en_i;
        default: gate_w = m_en_i;
      endcase
    end
    assign surv_o[b] = act_w[b] & gate_w;
  end

endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int N = 64,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);

  // Scan from the top so the last hit written is the lowest set bit.
  function automatic logic [IW-1:0] trailing_zeros(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  assign any_o = |vec_i;
  assign idx_o = trailing_zeros(vec_i);

endmodule

// File: rtl/irq_delegated_select.sv
module irq_delegated_select #(
  parameter int N       = 64,
  parameter bit REG_OUT = 1'b1,
  localparam int IW     = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  en_i,
  input  logic [N-1:0]  mdeleg_i,
  input  logic [N-1:0]  hdeleg_i,
  input  logic [1:0]    priv_i,
  input  logic          virt_i,
  input  logic          mie_i,
  input  logic          sie_i,
  output logic          irq_valid_o,
  output logic [IW-1:0] irq_idx_o
);

  logic          m_en_w, s_en_w, hs_en_w, vs_en_w;
  logic [N-1:0]  surv_w;
  logic          any_w;
  logic [IW-1:0] pick_w;

  irq_gate_en u_gate (
    .priv_i  (priv_i),
    .virt_i  (virt_i),
    .mie_i   (mie_i),
    .sie_i   (sie_i),
    .m_en_o  (m_en_w),
    .s_en_o  (s_en_w),
    .hs_en_o (hs_en_w),
    .vs_en_o (vs_en_w)
  );

  irq_group_mask #(.N(N)) u_mask (
    .pend_i   (pend_i),
    .en_i     (en_i),
    .mdeleg_i (mdeleg_i),
    .hdeleg_i (hdeleg_i),
    .m_en_i   (m_en_w),
    .hs_en_i  (hs_en_w),
    .vs_en_i  (vs_en_w),
    .surv_o   (surv_w)
  );

  irq_lowest_pick #(.N(N)) u_pick (
    .vec_i (surv_w),
    .any_o (any_w),
    .idx_o (pick_w)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        irq_valid_o <= 1'b0;
        irq_idx_o   <= '0;
      end else begin
        irq_valid_o <= any_w;
        irq_idx_o   <= pick_w;
      end
    end
  end else begin : g_comb
    assign irq_valid_o = any_w;
    assign irq_idx_o   = pick_w;
  end

endmodule

// File: rtl/irq_sel_chk.sv
module irq_sel_chk #(
  parameter int N       = 64,
  parameter bit REG_OUT = 1'b1,
  localparam int IW     = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  pend_i,
  input logic [N-1:0]  en_i,
  input logic [N-1:0]  mdeleg_i,
  input logic [N-1:0]  hdeleg_i,
  input logic [1:0]    priv_i,
  input logic          virt_i,
  input logic          mie_i,
  input logic [N-1:0]  surv_w,
  input logic          irq_valid_o,
  input logic [IW-1:0] irq_idx_o
);

  logic [N-1:0] seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= surv_w;
  end

  logic [N-1:0] ref_v;
  assign ref_v = REG_OUT ? seen_q : surv_w;

  // R2
  subset_of_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (surv_w & ~(pend_i & en_i)) == '0);

  // R5
  mach_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == 2'd3 && !mie_i) |-> ((surv_w & ~mdeleg_i) == '0));

  // R7
  guest_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !virt_i |-> ((surv_w & mdeleg_i & hdeleg_i) == '0));

  // R8
  winner_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> ref_v[irq_idx_o]);

  // R8
  winner_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> ((ref_v & ((N'(1) << irq_idx_o) - N'(1))) == '0));

  // R9
  none_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_v == '0) |-> (!irq_valid_o && irq_idx_o == '0));

endmodule

bind irq_delegated_select irq_sel_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pend_i      (pend_i),
  .en_i        (en_i),
  .mdeleg_i    (mdeleg_i),
  .hdeleg_i    (hdeleg_i),
  .priv_i      (priv_i),
  .virt_i      (virt_i),
  .mie_i       (mie_i),
  .surv_w      (surv_w),
  .irq_valid_o (irq_valid_o),
  .irq_idx_o   (irq_idx_o)
);

// File: tb/sim_irq_delegated_select.sv
module sim_irq_delegated_select;

  localparam int N  = 64;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pend, en, md, hd;
  logic [1:0]    priv;
  logic          virt, mie, sie;
  logic          vld;
  logic [IW-1:0] idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irq_delegated_select #(.N(N), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .mdeleg_i(md),
    .hdeleg_i(hd), .priv_i(priv), .virt_i(virt), .mie_i(mie), .sie_i(sie),
    .irq_valid_o(vld), .irq_idx_o(idx)
  );

  // Bench model: decide each line's gate, then walk upward to the first survivor.
  function automatic bit line_ok(input bit m, input bit h, input logic [1:0] p,
                                 input bit v, input bit me, input bit se);
    bit men, sen;
    men = (p != 2'd3) || me;
    sen = (p == 2'd0) || (p == 2'd1 && se);
    if (!m)     return men;
    else if (!h) return v || sen;
    else        return v && sen;
  endfunction

  task automatic expect_out(output bit ev, output int ei);
    ev = 1'b0; ei = 0;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && en[i] && line_ok(md[i], hd[i], priv, virt, mie, sie)) begin
        ev = 1'b1; ei = i;
        break;
      end
    end
  endtask

  task automatic check(input string tag, input bit ev, input int ei);
    checks++;
    if (vld !== ev || int'(idx) !== ei) begin
      fails++;
      $display("FAIL %s: got valid=%0b idx=%0d, want valid=%0b idx=%0d",
               tag, vld, idx, ev, ei);
    end
  endtask

  // Apply inputs after a falling edge, let one rising edge register them, sample at the next falling edge.
  task automatic apply_and_check(input string tag);
    bit ev; int ei;
    expect_out(ev, ei);
    @(posedge clk);
    @(negedge clk);
    check(tag, ev, ei);
  endtask

  task automatic set_in(input logic [N-1:0] p, input logic [N-1:0] e,
                        input logic [N-1:0] m, input logic [N-1:0] h,
                        input logic [1:0] pr, input bit v, input bit me, input bit se);
    pend = p; en = e; md = m; hd = h; priv = pr; virt = v; mie = me; sie = se;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    set_in('1, '1, '0, '0, 2'd0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R1 in reset", 1'b0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // One edge already sees rst_n high only at the next posedge; check first-cycle output.
    check("R1 after release", 1'b0, 0);

    set_in('0, '1, '0, '0, 2'd0, 1'b0, 1'b1, 1'b1);
    apply_and_check("R9 nothing pending");

    set_in(64'h10, 64'hEF, '0, '0, 2'd0, 1'b0, 1'b1, 1'b1);
    apply_and_check("R2 pending but disabled");

    set_in(64'h8000_0000_0000_0000, '1, '0, '0, 2'd1, 1'b0, 1'b0, 1'b0);
    apply_and_check("R8 top bit only");

    set_in(64'h8000_0000_0000_0001, '1, '0, '0, 2'd1, 1'b0, 1'b0, 1'b0);
    apply_and_check("R8 bit 0 beats top bit");

    set_in(64'h0F0, '1, '0, '0, 2'd3, 1'b0, 1'b0, 1'b0);
    apply_and_check("R3 R5 machine mode, mie clear");

    set_in(64'h0F0, '1, '0, '0, 2'd3, 1'b0, 1'b1, 1'b0);
    apply_and_check("R3 R5 machine mode, mie set");

    set_in(64'h0F0, '1, '0, '0, 2'd2, 1'b0, 1'b0, 1'b0);
    apply_and_check("R3 reserved privilege below machine");

    set_in(64'h0F0, '1, 64'h0F0, '0, 2'd1, 1'b0, 1'b0, 1'b0);
    apply_and_check("R4 R6 supervisor, sie clear");

    set_in(64'h0F0, '1, 64'h0F0, '0, 2'd0, 1'b0, 1'b0, 1'b0);
    apply_and_check("R4 R6 user mode opens supervisor");

    set_in(64'h0F0, '1, 64'h0F0, '0, 2'd2, 1'b0, 1'b0, 1'b1);
    apply_and_check("R4 reserved privilege closes supervisor");

    set_in(64'h0F0, '1, 64'h0F0, '0, 2'd1, 1'b1, 1'b0, 1'b0);
    apply_and_check("R6 virt opens host group");

    set_in(64'h0F0, '1, 64'h0F0, 64'h0F0, 2'd0, 1'b0, 1'b0, 1'b0);
    apply_and_check("R7 guest group closed without virt");

    set_in(64'h0F0, '1, 64'h0F0, 64'h0F0, 2'd0, 1'b1, 1'b0, 1'b0);
    apply_and_check("R7 guest group open with virt in user");

    set_in(64'h0F0, '1, 64'h0F0, 64'h0F0, 2'd1, 1'b1, 1'b0, 1'b0);
    apply_and_check("R7 guest group closed, sie clear in supervisor");

    set_in(64'h0F1, '1, 64'h001, 64'h001, 2'd3, 1'b0, 1'b1, 1'b1);
    apply_and_check("R5 R7 mixed groups, low guest line blocked");

    for (int k = 0; k < 400; k++) begin
      logic [N-1:0] p;
      p = {$urandom, $urandom};
      if (k % 3 == 0) p = p & {$urandom, $urandom} & {$urandom, $urandom};
      if (k % 7 == 0) p = '0;
      set_in(p, {$urandom, $urandom} | {$urandom, $urandom}, {$urandom, $urandom},
             {$urandom, $urandom}, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      apply_and_check("R8 R10 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule